// File: doc/BRIEF.md
# Conditional-Row Microprogram Sequencer

This block is a microprogrammed Mealy controller. Its program store holds a small set of rows. Each row carries four fields: the address it belongs to, the address to go to next, a ternary condition pattern over the live status bits, and a control word for the datapath. More than one row may carry the same address. While a run is active, the sequencer picks one row in every cycle. That row must belong to the current address and its condition pattern must agree with the status inputs. The sequencer then puts the row's control word on its output and moves to the row's next address.

Branching has no field of its own. It comes from several rows that share an address and differ in their condition patterns. A loop is a row whose next address is its own address. Next address 0 means the program is finished, and the run then ends with `done`. If no row fits the current address and status, the run ends with `err` set. The rows are loaded through a write port. A `start` pulse begins a run at address 1. A cycle counter reports how many microinstructions the last run executed.

Top module: `mprog_seq`

## Requirements
- R1: After a synchronous reset, `cur_addr` is 1, `cycles` is 0, and `busy`, `done`, `err` and `ctrl_valid` are all low.
- R2: When `start` is high while `busy` is low, the next clock sets `busy` high, sets `cur_addr` to 1, clears `cycles` and clears `done` and `err`.
- R3: A row fits only if its address field equals `cur_addr` and, for every condition bit whose care bit is 1, the status bit equals the row's value bit. A care bit of 0 means the bit is ignored.
- R4: When several rows fit in the same cycle, the row with the lowest index is used.
- R5: After a fitting row executes, `cur_addr` takes that row's next-address field. A next address equal to the row's own address repeats that address, which forms a loop.
- R6: One clock after a row fits, `ctrl_word` carries that row's control word and `ctrl_valid` is high. Otherwise `ctrl_valid` is low and `ctrl_word` is 0.
- R7: When the executed row's next address is 0, the same clock drops `busy` and raises `done`.
- R8: When no row fits during a run, the next clock drops `busy`, raises `err`, keeps `ctrl_valid` low and leaves `cycles` unchanged.
- R9: `cycles` goes up by one for every row executed in the current run and holds its value after the run ends.
- R10: `start` has no effect while `busy` is high.
- R11: A clock with `wr_en` high stores the address, next, care, value and control word fields into row `wr_row`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | 4 | Index of the row to write |
| wr_addr | input | 4 | Address field of the row |
| wr_next | input | 4 | Next-address field (0 = end) |
| wr_care | input | 4 | Care mask; 1 = the condition bit is compared |
| wr_val | input | 4 | Required value of each cared condition bit |
| wr_word | input | 8 | Control word of the row |
| start | input | 1 | Begins a run at address 1 when idle |
| status | input | 4 | Live condition bits from the datapath |
| ctrl_word | output | 8 | Registered control word of the executed row |
| ctrl_valid | output | 1 | High while `ctrl_word` carries an executed row |
| cur_addr | output | 4 | Current microprogram address |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run reached the end code |
| err | output | 1 | The last run stopped because no row fitted |
| cycles | output | 16 | Rows executed in the current or last run |

## Verification
The first program is run with three constant status patterns. The first pattern takes one branch at address 2. It also has a lower-priority catch-all row that fits at the same time, which shows the lowest-index rule. The second pattern takes the other branch. The third leaves address 4 with no fitting row, which must end in the error state rather than in done. A second program is then loaded. In it, address 3 loops on one status bit. The bench clears that bit partway through the run, so the number of repeated words tells whether the sequencer samples status live. A `start` pulse during that loop must not restart the run.

// File: rtl/mprog_seq_pkg.sv
package mprog_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_DONE  = 2'd2,
    PH_FAULT = 2'd3
  } phase_t;

  // True when a next-address value is the reserved end code (all zero).
  function automatic logic is_end_code(input logic [31:0] a, input int unsigned aw);
    logic [31:0] m;
    m = (aw >= 32) ? 32'hFFFF_FFFF : ((32'd1 << aw) - 32'd1);
    return (a & m) == 32'd0;
  endfunction

endpackage

// File: rtl/mprog_seq_rows.sv
module mprog_seq_rows #(
  parameter int ROWS  = 16,
  parameter int AW    = 4,
  parameter int NCOND = 4,
  parameter int CW    = 8,
  localparam int IW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IW-1:0]              wr_row,
  input  logic [AW-1:0]              wr_addr,
  input  logic [AW-1:0]              wr_next,
  input  logic [NCOND-1:0]           wr_care,
  input  logic [NCOND-1:0]           wr_val,
  input  logic [CW-1:0]              wr_word,
  output logic [ROWS-1:0][AW-1:0]    row_addr,
  output logic [ROWS-1:0][AW-1:0]    row_next,
  output logic [ROWS-1:0][NCOND-1:0] row_care,
  output logic [ROWS-1:0][NCOND-1:0] row_val,
  output logic [ROWS-1:0][CW-1:0]    row_word
);

  // All rows are read in parallel every cycle, so the store is flops.
  // A cleared row has address 0, which never equals a live address.
  for (genvar i = 0; i < ROWS; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst) begin
        row_addr[i] <= '0;
        row_next[i] <= '0;
        row_care[i] <= '0;
        row_val[i]  <= '0;
        row_word[i] <= '0;
      end else if (wr_en && (wr_row == IW'(i))) begin
        row_addr[i] <= wr_addr;
        row_next[i] <= wr_next;
        row_care[i] <= wr_care;
        row_val[i]  <= wr_val & wr_care;
        row_word[i] <= wr_word;
      end
    end
  end

endmodule

// File: rtl/mprog_seq_match.sv
module mprog_seq_match #(
  parameter int ROWS  = 16,
  parameter int AW    = 4,
  parameter int NCOND = 4,
  parameter int CW    = 8
) (
  input  logic [AW-1:0]              cur_addr,
  input  logic [NCOND-1:0]           status,
  input  logic [ROWS-1:0][AW-1:0]    row_addr,
  input  logic [ROWS-1:0][AW-1:0]    row_next,
  input  logic [ROWS-1:0][NCOND-1:0] row_care,
  input  logic [ROWS-1:0][NCOND-1:0] row_val,
  input  logic [ROWS-1:0][CW-1:0]    row_word,
  output logic                       hit,
  output logic [AW-1:0]              hit_next,
  output logic [CW-1:0]              hit_word
);

  logic [ROWS-1:0] fits;

  for (genvar i = 0; i < ROWS; i++) begin : g_cmp
    assign fits[i] = (row_addr[i] == cur_addr) &&
                     (((status ^ row_val[i]) & row_care[i]) == '0);
  end

  // Lowest index wins: scan from the top so the last assignment is the lowest.
  always_comb begin
    hit      = 1'b0;
    hit_next = '0;
    hit_word = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (fits[i]) begin
        hit      = 1'b1;
        hit_next = row_next[i];
        hit_word = row_word[i];
      end
    end
  end

endmodule

// File: rtl/mprog_seq_ctrl.sv
module mprog_seq_ctrl
  import mprog_seq_pkg::*;
#(
  parameter int AW   = 4,
  parameter int CW   = 8,
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            hit,
  input  logic [AW-1:0]   hit_next,
  input  logic [CW-1:0]   hit_word,
  output logic [AW-1:0]   cur_addr,
  output logic [CW-1:0]   ctrl_word,
  output logic            ctrl_valid,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [CNTW-1:0] cycles
);

  localparam logic [AW-1:0] FIRST_ADDR = AW'(1);

  phase_t phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      cur_addr   <= FIRST_ADDR;
      ctrl_word  <= '0;
      ctrl_valid <= 1'b0;
      cycles     <= '0;
    end else begin
      ctrl_word  <= '0;
      ctrl_valid <= 1'b0;
      if (phase == PH_RUN) begin
        if (hit) begin
          ctrl_word  <= hit_word;
          ctrl_valid <= 1'b1;
          cycles     <= cycles + CNTW'(1);
          cur_addr   <= hit_next;
          if (is_end_code(32'(hit_next), AW)) phase <= PH_DONE;
        end else begin
          phase <= PH_FAULT;
        end
      end else if (start) begin
        phase    <= PH_RUN;
        cur_addr <= FIRST_ADDR;
        cycles   <= '0;
      end
    end
  end

  assign busy = (phase == PH_RUN);
  assign done = (phase == PH_DONE);
  assign err  = (phase == PH_FAULT);

endmodule

// File: rtl/mprog_seq.sv
module mprog_seq #(
  parameter int ROWS  = 16,
  parameter int AW    = 4,
  parameter int NCOND = 4,
  parameter int CW    = 8,
  parameter int CNTW  = 16,
  localparam int IW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_row,
  input  logic [AW-1:0]    wr_addr,
  input  logic [AW-1:0]    wr_next,
  input  logic [NCOND-1:0] wr_care,
  input  logic [NCOND-1:0] wr_val,
  input  logic [CW-1:0]    wr_word,
  input  logic             start,
  input  logic [NCOND-1:0] status,
  output logic [CW-1:0]    ctrl_word,
  output logic             ctrl_valid,
  output logic [AW-1:0]    cur_addr,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [CNTW-1:0]  cycles
);

  logic [ROWS-1:0][AW-1:0]    r_addr;
  logic [ROWS-1:0][AW-1:0]    r_next;
  logic [ROWS-1:0][NCOND-1:0] r_care;
  logic [ROWS-1:0][NCOND-1:0] r_val;
  logic [ROWS-1:0][CW-1:0]    r_word;
  logic                       m_hit;
  logic [AW-1:0]              m_next;
  logic [CW-1:0]              m_word;

  mprog_seq_rows #(.ROWS(ROWS), .AW(AW), .NCOND(NCOND), .CW(CW)) u_rows (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_row   (wr_row),
    .wr_addr  (wr_addr),
    .wr_next  (wr_next),
    .wr_care  (wr_care),
    .wr_val   (wr_val),
    .wr_word  (wr_word),
    .row_addr (r_addr),
    .row_next (r_next),
    .row_care (r_care),
    .row_val  (r_val),
    .row_word (r_word)
  );

  mprog_seq_match #(.ROWS(ROWS), .AW(AW), .NCOND(NCOND), .CW(CW)) u_match (
    .cur_addr (cur_addr),
    .status   (status),
    .row_addr (r_addr),
    .row_next (r_next),
    .row_care (r_care),
    .row_val  (r_val),
    .row_word (r_word),
    .hit      (m_hit),
    .hit_next (m_next),
    .hit_word (m_word)
  );

  mprog_seq_ctrl #(.AW(AW), .CW(CW), .CNTW(CNTW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .hit        (m_hit),
    .hit_next   (m_next),
    .hit_word   (m_word),
    .cur_addr   (cur_addr),
    .ctrl_word  (ctrl_word),
    .ctrl_valid (ctrl_valid),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .cycles     (cycles)
  );

endmodule

// File: rtl/mprog_seq_checker.sv
module mprog_seq_checker #(
  parameter int AW   = 4,
  parameter int CW   = 8,
  parameter int CNTW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [CW-1:0]   ctrl_word,
  input logic            ctrl_valid,
  input logic [AW-1:0]   cur_addr,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic [CNTW-1:0] cycles
);

  // R2: an idle start opens a run at address 1 with a cleared counter
  p_idle_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && cur_addr == AW'(1) && cycles == '0));

  // R6: a valid word only follows a cycle that was running
  p_valid_after_run_r6: assert property (@(posedge clk) disable iff (rst)
    ctrl_valid |-> $past(busy));

  // R6: an idle output carries a zero word
  p_zero_word_r6: assert property (@(posedge clk) disable iff (rst)
    !ctrl_valid |-> (ctrl_word == '0));

  // R7: done and busy never coincide
  p_done_stops_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy, done, err}));

  // R8: entering error emits no word and keeps the count
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (!ctrl_valid && $stable(cycles)));

  // R9: every emitted word advances the count by one
  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl_valid |-> (cycles == CNTW'($past(cycles) + 1)));

  // R10: a start during a run does not clear a nonzero count
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && start && cycles != '0) |=> (cycles != '0));

endmodule

bind mprog_seq mprog_seq_checker #(.AW(AW), .CW(CW), .CNTW(CNTW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .ctrl_word  (ctrl_word),
  .ctrl_valid (ctrl_valid),
  .cur_addr   (cur_addr),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .cycles     (cycles)
);

// File: tb/mprog_seq_bench.sv
module mprog_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_row = '0;
  logic [3:0]  wr_addr = '0;
  logic [3:0]  wr_next = '0;
  logic [3:0]  wr_care = '0;
  logic [3:0]  wr_val = '0;
  logic [7:0]  wr_word = '0;
  logic        start = 1'b0;
  logic [3:0]  status = '0;
  logic [7:0]  ctrl_word;
  logic        ctrl_valid;
  logic [3:0]  cur_addr;
  logic        busy;
  logic        done;
  logic        err;
  logic [15:0] cycles;

  int n_chk = 0;
  int n_bad = 0;
  int wd = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  mprog_seq u_mprog_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row), .wr_addr(wr_addr),
    .wr_next(wr_next), .wr_care(wr_care), .wr_val(wr_val), .wr_word(wr_word),
    .start(start), .status(status), .ctrl_word(ctrl_word), .ctrl_valid(ctrl_valid),
    .cur_addr(cur_addr), .busy(busy), .done(done), .err(err), .cycles(cycles)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected words as the design emits them (R6).
  always @(negedge clk) begin
    if (!rst && ctrl_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected word", int'(ctrl_word), 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(ctrl_word == e, "R6 word", int'(ctrl_word), int'(e));
      end
    end
  end

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 20000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 20000);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic put_row(input int idx, input int a, input int nx,
                         input int care, input int val, input int w);
    @(negedge clk);
    wr_en = 1'b1; wr_row = 4'(idx); wr_addr = 4'(a); wr_next = 4'(nx);
    wr_care = 4'(care); wr_val = 4'(val); wr_word = 8'(w);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic begin_run(input logic [3:0] st);
    status = st;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && cur_addr == 4'd1, "R2 run opens at 1", int'({busy, cur_addr}), 'h11);
  endtask

  task automatic wait_end();
    for (int k = 0; k < 100; k++) begin
      if (done || err) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(cur_addr == 4'd1, "R1 address", int'(cur_addr), 1);
    chk(!busy && !done && !err, "R1 flags", int'({busy, done, err}), 0);
    chk(cycles == 16'd0 && !ctrl_valid, "R1 count/valid", int'(cycles), 0);

    // R11: program load. care=1 compares the bit, 0 ignores it.
    put_row(0, 1, 2, 'b0000, 'b0000, 'h11);
    put_row(1, 2, 3, 'b0001, 'b0001, 'h21);
    put_row(2, 2, 4, 'b0001, 'b0000, 'h22);
    put_row(3, 2, 0, 'b0000, 'b0000, 'h2F); // R4: always fits, loses on index
    put_row(4, 3, 0, 'b0000, 'b0000, 'h31);
    put_row(5, 4, 0, 'b0010, 'b0010, 'h41);

    // Run A: status bit0 set -> branch 21 (R3, R4)
    exp_q.push_back(8'h11); exp_q.push_back(8'h21); exp_q.push_back(8'h31);
    begin_run(4'b0001);
    wait_end();
    @(negedge clk);
    chk(done && !busy && !err, "R7 done", int'({done, busy, err}), 4);
    chk(cycles == 16'd3, "R9 count A", int'(cycles), 3);
    chk(exp_q.size() == 0, "R4 words A", exp_q.size(), 0);

    // Run B: other branch, address 4 needs bit1 (R3)
    exp_q.push_back(8'h11); exp_q.push_back(8'h22); exp_q.push_back(8'h41);
    begin_run(4'b0010);
    wait_end();
    @(negedge clk);
    chk(done && cycles == 16'd3, "R3 run B", int'(cycles), 3);
    chk(cur_addr == 4'd0, "R5 end address", int'(cur_addr), 0);

    // Run C: address 4 has no fitting row -> error (R8)
    exp_q.push_back(8'h11); exp_q.push_back(8'h22);
    begin_run(4'b0000);
    wait_end();
    @(negedge clk);
    chk(err && !done && !busy, "R8 error", int'({err, done, busy}), 4);
    chk(cycles == 16'd2, "R8 count kept", int'(cycles), 2);
    chk(!ctrl_valid, "R8 no word", int'(ctrl_valid), 0);

    // Loop program: address 3 repeats while status bit2 is set (R5, R11)
    put_row(4, 3, 3, 'b0100, 'b0100, 'h33);
    put_row(6, 3, 0, 'b0100, 'b0000, 'h30);
    exp_q.push_back(8'h11); exp_q.push_back(8'h21);
    exp_q.push_back(8'h33); exp_q.push_back(8'h33); exp_q.push_back(8'h33);
    exp_q.push_back(8'h30);
    begin_run(4'b0101);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(cur_addr == 4'd3 && busy, "R5 loop address", int'(cur_addr), 3);
    start = 1'b1;                 // R10: must be ignored
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    status = 4'b0001;
    wait_end();
    @(negedge clk);
    chk(done, "R10 run not restarted", int'(done), 1);
    chk(cycles == 16'd6, "R9 loop count", int'(cycles), 6);
    chk(exp_q.size() == 0, "R5 loop words", exp_q.size(), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule